// File: doc/BRIEF.md
# ADC Single-Conversion Start Controller

This block holds the control byte for one analog-to-digital channel running one conversion at a time, and sequences each conversion from start to completion. Software writes the byte to choose how a conversion begins: either by writing a start command, or by a rising edge on one of four hardware trigger lines picked by a two-bit code. A stop command aborts a running conversion at once.

The analog converter is not part of the block. Its conversion time is modelled by a busy counter of fixed, parameterised length. A read-only done flag shows whether the last conversion has finished. When a conversion completes, the block sends a one-cycle pulse to either an interrupt request line or a DMA request line, as the control byte selects.

A comparator-mode input stops hardware triggers from starting anything, so only the software start command begins an operation.

Top module: `adc_oneshot_ctl`

## Requirements
- R1: After reset, `rd_data` reads 0x04 (done flag set, every other bit 0), `busy` is 0, and neither request output is high.
- R2: Bits 7, 5, 4 and 3 of the control byte read back as last written. Bit 6 has no function and always reads 0.
- R3: Bit 0 (start command) and bit 1 (stop command) act only when written as 1, and both always read as 0.
- R4: Writing bit 0 = 1 while idle (with bit 1 = 0) makes `busy` 1 and clears the done flag (bit 2) from the next cycle.
- R5: A conversion holds `busy` for exactly CONV_CYCLES cycles. After that the done flag reads 1.
- R6: On completion, exactly one one-cycle pulse appears, in the cycle after the last busy cycle. It goes on `irq_req` when bit 3 = 0 and on `dma_req` when bit 3 = 1. The two outputs are never high together.
- R7: With bit 4 = 1 and `cmp_mode` = 0, a rising edge on `hw_trig[{bit7,bit5}]` starts a conversion. `busy` rises on the third clock edge after the input rises. The other trigger lines are ignored.
- R8: With bit 4 = 0, the hardware trigger lines have no effect.
- R9: With `cmp_mode` = 1, the hardware trigger lines have no effect, and a software start still works.
- R10: A start (software or hardware) that arrives while `busy` is 1 is ignored. The running conversion keeps its length and produces only one pulse.
- R11: Writing bit 1 = 1 makes `busy` 0 on the next cycle, sets the done flag, and produces no request pulse. If bits 0 and 1 are written together, the stop wins.
- R12: A hardware trigger held high starts only one conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Control byte write value |
| rd_data | output | 8 | Control byte read value |
| cmp_mode | input | 1 | Comparator mode; hardware triggers ignored while high |
| hw_trig | input | 4 | Asynchronous hardware trigger lines |
| busy | output | 1 | Conversion in progress |
| irq_req | output | 1 | One-cycle completion pulse, interrupt route |
| dma_req | output | 1 | One-cycle completion pulse, DMA route |

## Verification
The bench builds the block with CONV_CYCLES = 5 and SYNC_STAGES = 2. The short conversion lets many complete conversions fit in a short run: every trigger code, both request routes, an overlapping start, and both stop cases. Two synchroniser stages fix the trigger-to-busy latency at three edges, so the scoreboard can predict the exact completion cycle of every conversion. It can also tell a pulse that was never expected from a pulse that arrives late.

// File: rtl/adc_oneshot_pkg.sv
package adc_oneshot_pkg;
   localparam int unsigned REG_W  = 8;
   localparam int unsigned TSEL_W = 2;
   localparam int unsigned N_TRIG = 1 << TSEL_W;

   // control byte bit positions
   localparam int unsigned B_START = 0;
   localparam int unsigned B_STOP  = 1;
   localparam int unsigned B_DONE  = 2;
   localparam int unsigned B_REQ   = 3;
   localparam int unsigned B_HWSEL = 4;
   localparam int unsigned B_TLO   = 5;
   localparam int unsigned B_RSVD  = 6;
   localparam int unsigned B_THI   = 7;

   typedef struct packed {
      logic [TSEL_W-1:0] tsel;
      logic              hw_sel;
      logic              req_dma;
   } cfg_t;
endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
   parameter int unsigned N_IN        = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_IN-1:0] trig_in,
   output logic [N_IN-1:0] rise
);
   genvar gi;
   generate
      for (gi = 0; gi < N_IN; gi++) begin : g_line
         logic [SYNC_STAGES:0] sh_q;
         always_ff @(posedge clk) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[SYNC_STAGES-1:0], trig_in[gi]};
         end
         assign rise[gi] = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
      end
   endgenerate
endmodule

// File: rtl/adc_cfg_reg.sv
module adc_cfg_reg
   import adc_oneshot_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic             done_flag,
   output cfg_t             cfg,
   output logic [REG_W-1:0] rd_data
);
   cfg_t cfg_q;
   logic unused_bits;

   assign unused_bits = ^{wr_data[B_RSVD], wr_data[B_DONE], wr_data[B_STOP], wr_data[B_START]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (wr_en) begin
         cfg_q.tsel    <= {wr_data[B_THI], wr_data[B_TLO]};
         cfg_q.hw_sel  <= wr_data[B_HWSEL];
         cfg_q.req_dma <= wr_data[B_REQ];
      end
   end

   always_comb begin
      rd_data          = '0;
      rd_data[B_THI]   = cfg_q.tsel[1];
      rd_data[B_TLO]   = cfg_q.tsel[0];
      rd_data[B_HWSEL] = cfg_q.hw_sel;
      rd_data[B_REQ]   = cfg_q.req_dma;
      rd_data[B_DONE]  = done_flag;
   end

   assign cfg = cfg_q;
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
   parameter int unsigned CONV_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic stop,
   output logic busy,
   output logic done_flag,
   output logic last
);
   localparam int unsigned CW = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
   localparam logic [CW-1:0] LAST_CNT = CW'(CONV_CYCLES - 1);

   logic          busy_q;
   logic          done_q;
   logic [CW-1:0] cnt_q;

   assign last = busy_q & ~stop & (cnt_q == LAST_CNT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b1;
         cnt_q  <= '0;
      end else if (stop) begin
         busy_q <= 1'b0;
         done_q <= 1'b1;
         cnt_q  <= '0;
      end else if (busy_q) begin
         if (last) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end else if (start) begin
         busy_q <= 1'b1;
         done_q <= 1'b0;
         cnt_q  <= '0;
      end
   end

   assign busy      = busy_q;
   assign done_flag = done_q;
endmodule

// File: rtl/adc_oneshot_ctl.sv
module adc_oneshot_ctl
   import adc_oneshot_pkg::*;
#(
   parameter int unsigned CONV_CYCLES = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_W-1:0]  wr_data,
   output logic [REG_W-1:0]  rd_data,
   input  logic              cmp_mode,
   input  logic [N_TRIG-1:0] hw_trig,
   output logic              busy,
   output logic              irq_req,
   output logic              dma_req
);
   generate
      if (CONV_CYCLES < 1) begin : g_bad_len
         $error("CONV_CYCLES must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   cfg_t              cfg;
   logic              done_flag;
   logic [N_TRIG-1:0] rise;
   logic              sw_go, hw_go, stop_go, last;
   logic              irq_q, dma_q;

   adc_trig_sync #(.N_IN(N_TRIG), .SYNC_STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .trig_in(hw_trig), .rise(rise)
   );

   adc_cfg_reg cfg_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .done_flag(done_flag), .cfg(cfg), .rd_data(rd_data)
   );

   assign sw_go   = wr_en & wr_data[B_START];
   assign stop_go = wr_en & wr_data[B_STOP];
   assign hw_go   = cfg.hw_sel & ~cmp_mode & rise[cfg.tsel];

   adc_conv_seq #(.CONV_CYCLES(CONV_CYCLES)) seq_i (
      .clk(clk), .rst_n(rst_n), .start(sw_go | hw_go), .stop(stop_go),
      .busy(busy), .done_flag(done_flag), .last(last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
         dma_q <= 1'b0;
      end else begin
         irq_q <= last & ~cfg.req_dma;
         dma_q <= last &  cfg.req_dma;
      end
   end

   assign irq_req = irq_q;
   assign dma_req = dma_q;
endmodule

// File: rtl/adc_oneshot_chk.sv
module adc_oneshot_chk #(
   parameter int unsigned CONV_CYCLES = 16
) (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [7:0] wr_data,
   input logic [7:0] rd_data,
   input logic       busy,
   input logic       irq_req,
   input logic       dma_req
);
   int unsigned run_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    run_q <= 0;
      else if (busy) run_q <= run_q + 1;
      else           run_q <= 0;
   end

   a_r3_cmd_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[1:0] == 2'b00);
   a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[6] == 1'b0);
   a_r4_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && wr_en && wr_data[0] && !wr_data[1]) |=> (busy && !rd_data[2]));
   a_r5_busy_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !rd_data[2]);
   a_r6_never_both: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_req && dma_req));
   a_r6_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |=> !irq_req);
   a_r6_dma_single: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |=> !dma_req);
   a_r6_pulse_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req || dma_req) |-> ($past(busy) && !busy && rd_data[2]));
   a_r10_full_length: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req || dma_req) |-> (run_q == CONV_CYCLES));
   a_r11_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[1]) |=> (!busy && rd_data[2] && !irq_req && !dma_req));
endmodule

bind adc_oneshot_ctl adc_oneshot_chk #(.CONV_CYCLES(CONV_CYCLES)) chk_i (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
   .rd_data(rd_data), .busy(busy), .irq_req(irq_req), .dma_req(dma_req)
);

// File: tb/adc_oneshot_ctl_tb.sv
module adc_oneshot_ctl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int N = 5;

   typedef struct {
      bit dma;
      int cyc;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       cmp_mode = 1'b0;
   logic [3:0] hw_trig = 4'h0;
   logic       busy, irq_req, dma_req;

   exp_t q[$];
   int cyc = 0;
   int nchk = 0;
   int nerr = 0;
   int npulse = 0;

   adc_oneshot_ctl #(.CONV_CYCLES(N), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .cmp_mode(cmp_mode), .hw_trig(hw_trig),
      .busy(busy), .irq_req(irq_req), .dma_req(dma_req)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string req, input int act, input int exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && (irq_req || dma_req)) begin
         npulse++;
         check("R6 one route only", int'(irq_req && dma_req), 0);
         if (q.size() == 0) begin
            check("R10/R11 unexpected pulse", 1, 0);
         end else begin
            exp_t e;
            e = q.pop_front();
            check("R6 route", int'(dma_req), int'(e.dma));
            check("R5 completion cycle", cyc, e.cyc);
         end
      end
   end

   task automatic wr(input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = 8'h00;
   endtask

   task automatic sw_start(input logic [7:0] cfgb, input bit expect_pulse);
      @(negedge clk);
      if (expect_pulse) q.push_back('{dma: cfgb[3], cyc: cyc + N + 1});
      wr_en = 1'b1; wr_data = cfgb | 8'h01;
      @(negedge clk);
      wr_en = 1'b0; wr_data = 8'h00;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic blip(input int idx);
      @(negedge clk);
      hw_trig[idx] = 1'b1;
      idle(4);
      hw_trig[idx] = 1'b0;
      idle(4);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      nchk++; nerr++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      check("R1 rd_data", rd_data, 8'h04);
      check("R1 busy", busy, 0);
      check("R1 requests", {irq_req, dma_req}, 0);

      // R2 readback, reserved bit
      wr(8'hF8);
      check("R2 readback F8", rd_data, 8'hBC);
      wr(8'h00);
      check("R2 readback 00", rd_data, 8'h04);

      // R4/R5/R6 software start, interrupt route
      sw_start(8'h00, 1);
      check("R4 busy after start", busy, 1);
      check("R4 R3 rd during busy", rd_data, 8'h00);
      idle(N + 2);
      check("R5 done flag", rd_data, 8'h04);
      check("R5 idle", busy, 0);

      // R6 DMA route
      sw_start(8'h08, 1);
      check("R3 rd during dma run", rd_data, 8'h08);
      idle(N + 2);
      check("R6 done flag dma", rd_data, 8'h0C);

      // R10 start while busy ignored
      begin
         int p0;
         p0 = npulse;
         sw_start(8'h00, 1);
         idle(1);
         wr(8'h01);
         check("R10 still busy", busy, 1);
         idle(N + 3);
         check("R10 single pulse", npulse - p0, 1);
      end

      // R11 stop aborts
      begin
         int p0;
         sw_start(8'h00, 0);
         idle(1);
         wr(8'h02);
         check("R11 busy after stop", busy, 0);
         check("R11 done after stop", rd_data, 8'h04);
         p0 = npulse;
         idle(N + 3);
         check("R11 no pulse after stop", npulse - p0, 0);
         wr(8'h03);
         check("R11 stop beats start", busy, 0);
         check("R11 done with both", rd_data, 8'h04);
      end

      // R7/R12 hardware triggers, every code
      for (int c = 0; c < 4; c++) begin
         logic [7:0] cfgb;
         int p0;
         cfgb = {c[1], 1'b0, c[0], 1'b1, (c == 3), 3'b000};
         wr(cfgb);
         blip((c + 1) % 4);
         check("R7 other line ignored", busy, 0);
         p0 = npulse;
         @(negedge clk);
         q.push_back('{dma: cfgb[3], cyc: cyc + 3 + N});
         hw_trig[c] = 1'b1;
         idle(2);
         check("R7 not yet busy", busy, 0);
         idle(1);
         check("R7 busy on third edge", busy, 1);
         idle(N + 10);
         check("R12 held trigger one run", npulse - p0, 1);
         hw_trig[c] = 1'b0;
         idle(4);
      end

      // R8 software-only mode ignores triggers
      begin
         int p0;
         wr(8'h00);
         p0 = npulse;
         blip(0);
         check("R8 trigger ignored", busy, 0);
         idle(N);
         check("R8 no pulse", npulse - p0, 0);
      end

      // R9 comparator mode
      begin
         int p0;
         cmp_mode = 1'b1;
         wr(8'h10);
         p0 = npulse;
         blip(0);
         check("R9 trigger ignored", busy, 0);
         check("R9 no pulse", npulse - p0, 0);
         sw_start(8'h10, 1);
         check("R9 software start works", busy, 1);
         idle(N + 2);
         cmp_mode = 1'b0;
         check("R9 finished", rd_data, 8'h14);
      end

      idle(2);
      check("R6 all expected pulses seen", q.size(), 0);
      finish_run();
   end
endmodule